// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit watches the register numbers moving through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It resolves read-after-write dependences. For each ALU operand in the execute stage it picks where the value comes from: the register file, the execute/memory pipeline register, or the memory/writeback pipeline register. The register file hands a freshly written value straight to a read in the same cycle, so the unit needs no third bypass path from writeback into decode.

A value a load has not fetched yet cannot be bypassed in time. So when the instruction in decode reads the destination of a load sitting in execute, the unit freezes the program counter and the fetch/decode register for one cycle and sends a bubble (all-zero control) into execute. Branches are compared and their targets added in decode. A taken branch therefore costs one cycle: the unit asks for the fetch/decode register to be replaced by a no-op on the next clock. The unit is combinational. Its clock and reset only sample the built-in property checks.

Top module: `bypass_interlock_unit`

## Requirements
- R1: Each operand select is 2 bits at `fwd_sel[2i+1:2i]` for operand i (operand A is i=0). The codes are 00 = register file, 10 = execute/memory register, 01 = memory/writeback register. With no matching stage the select is 00.
- R2: The select is 10 when the execute/memory stage writes a register (`exm_wen`=1) and that register equals the operand's source register and is nonzero.
- R3: The select is 01 when the execute/memory stage does not qualify and the memory/writeback stage writes a nonzero register equal to the operand's source register.
- R4: When both stages qualify for the same operand, the execute/memory stage (the younger result) wins and the select is 10.
- R5: Register 0 is never bypassed. A source of 0 always selects 00.
- R6: A stage whose write enable is 0 is never a bypass source, even if its destination number matches.
- R7: When execute holds a load (`idex_load`=1, `idex_wen`=1) whose destination is nonzero and equals either decode source register, `pc_hold`, `ifid_hold` and `bubble_ins` are all 1. Otherwise all three are 0.
- R8: A non-load instruction in execute never causes a stall, whatever its destination.
- R9: `ifid_flush` is 1 exactly when `br_taken` is 1 and no load-use stall is active in the same cycle.
- R10: During a load-use stall a taken-branch indication is ignored: `ifid_flush` stays 0 and the stall outputs stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| ex_src | input | NUM_OPS*REG_AW | Source register numbers of the execute-stage operands |
| id_src | input | NUM_OPS*REG_AW | Source register numbers of the decode-stage instruction |
| idex_dst | input | REG_AW | Destination register of the instruction in execute |
| idex_wen | input | 1 | Instruction in execute writes a register |
| idex_load | input | 1 | Instruction in execute is a load |
| exm_dst | input | REG_AW | Destination held in the execute/memory register |
| exm_wen | input | 1 | Register-write enable in the execute/memory register |
| mwb_dst | input | REG_AW | Destination held in the memory/writeback register |
| mwb_wen | input | 1 | Register-write enable in the memory/writeback register |
| br_taken | input | 1 | Branch resolved taken in decode |
| fwd_sel | output | 2*NUM_OPS | Operand source selects |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| bubble_ins | output | 1 | Zero the control going into execute |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |

## Verification
The bypass selects are tried with:
- a match in one stage only, which separates the two codes;
- a match in both stages, which shows the priority;
- matching numbers with the write enable off, and sources of register 0, which show the qualifiers;
- two operands bypassed from different stages at once, which shows the operands are independent.

The interlock is tried with:
- a load hitting each decode source in turn;
- a non-load with a matching destination, which must not stall;
- a load writing register 0, which must not stall.

The branch is tried alone and together with a stall, which separates flush from hold.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_MEMWB   = 2'b01,
      SRC_EXMEM   = 2'b10
   } fwd_src_e;
endpackage

// File: rtl/bypass_select.sv
module bypass_select
   import bypass_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wen,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wen,
   output fwd_src_e          sel
);
   logic exm_ok, mwb_ok;

   generate
      if (ZERO_REG_HARD) begin : g_zero_hard
         assign exm_ok = exm_wen && (|exm_dst);
         assign mwb_ok = mwb_wen && (|mwb_dst);
      end else begin : g_zero_soft
         assign exm_ok = exm_wen;
         assign mwb_ok = mwb_wen;
      end
   endgenerate

   always_comb begin
      sel = SRC_REGFILE;
      if (exm_ok && (exm_dst == src))
         sel = SRC_EXMEM;
      else if (mwb_ok && (mwb_dst == src))
         sel = SRC_MEMWB;
   end

   // priority of the younger stage
   assert_exm_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_wen && exm_dst == src && src != '0 && mwb_wen && mwb_dst == src) |-> sel == SRC_EXMEM);
   // a selected stage must have write enable set and a matching register
   assert_exm_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_EXMEM) |-> (exm_wen && exm_dst == src));
   assert_mwb_needs_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_MEMWB) |-> (mwb_wen && mwb_dst == src));
   generate
      if (ZERO_REG_HARD) begin : g_zero_chk
         assert_no_zero_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (src == '0) |-> sel == SRC_REGFILE);
      end
   endgenerate
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
   parameter int REG_AW  = 5,
   parameter int NUM_OPS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_OPS*REG_AW-1:0] id_src,
   input  logic [REG_AW-1:0]         idex_dst,
   input  logic                      idex_wen,
   input  logic                      idex_load,
   output logic                      stall
);
   logic [NUM_OPS-1:0] hit;
   logic               ld_live;

   assign ld_live = idex_load && idex_wen && (|idex_dst);

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
      assign hit[i] = ld_live && (id_src[i*REG_AW +: REG_AW] == idex_dst);
   end

   assign stall = |hit;

   // non-loads never interlock
   assert_noload_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !idex_load |-> !stall);
   assert_stall_needs_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_wen && idex_dst != '0));
endmodule

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic br_taken,
   input  logic stall,
   output logic flush
);
   assign flush = br_taken && !stall;

   assert_flush_only_on_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> br_taken);
endmodule

// File: rtl/bypass_interlock_unit.sv
module bypass_interlock_unit
   import bypass_pkg::*;
#(
   parameter int REG_AW        = 5,
   parameter int NUM_OPS       = 2,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_OPS*REG_AW-1:0] ex_src,
   input  logic [NUM_OPS*REG_AW-1:0] id_src,
   input  logic [REG_AW-1:0]         idex_dst,
   input  logic                      idex_wen,
   input  logic                      idex_load,
   input  logic [REG_AW-1:0]         exm_dst,
   input  logic                      exm_wen,
   input  logic [REG_AW-1:0]         mwb_dst,
   input  logic                      mwb_wen,
   input  logic                      br_taken,
   output logic [2*NUM_OPS-1:0]      fwd_sel,
   output logic                      pc_hold,
   output logic                      ifid_hold,
   output logic                      bubble_ins,
   output logic                      ifid_flush
);
   localparam int SEL_W = 2 * NUM_OPS;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("REG_AW must lie in 1..8");
   end
   if (NUM_OPS < 1 || NUM_OPS > 4) begin : g_bad_ops
      $error("NUM_OPS must lie in 1..4");
   end

   logic     ld_stall;
   fwd_src_e op_sel [NUM_OPS];

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      bypass_select #(.REG_AW(REG_AW), .ZERO_REG_HARD(ZERO_REG_HARD)) sel_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (ex_src[i*REG_AW +: REG_AW]),
         .exm_dst (exm_dst),
         .exm_wen (exm_wen),
         .mwb_dst (mwb_dst),
         .mwb_wen (mwb_wen),
         .sel     (op_sel[i])
      );
      assign fwd_sel[2*i +: 2] = op_sel[i];
   end

   load_use_detect #(.REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) lud_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .id_src    (id_src),
      .idex_dst  (idex_dst),
      .idex_wen  (idex_wen),
      .idex_load (idex_load),
      .stall     (ld_stall)
   );

   branch_flush_ctrl bfc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .br_taken (br_taken),
      .stall    (ld_stall),
      .flush    (ifid_flush)
   );

   assign pc_hold    = ld_stall;
   assign ifid_hold  = ld_stall;
   assign bubble_ins = ld_stall;

   // stall requires a load in execute
   assert_hold_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (idex_load && idex_wen));
   // flush and hold never together
   assert_flush_vs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ifid_flush && ifid_hold));
   assert_sel_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fwd_sel) <= NUM_OPS);
   assert_taken_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> (ifid_flush || pc_hold));

   logic [SEL_W-1:0] unused_w;
   assign unused_w = fwd_sel;
endmodule

// File: tb/bypass_interlock_unit_tb.sv
`timescale 1ns/1ps
module bypass_interlock_unit_tb_top;
   localparam int AW = 5;
   localparam int NO = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NO*AW-1:0] ex_src = '0, id_src = '0;
   logic [AW-1:0] idex_dst = '0, exm_dst = '0, mwb_dst = '0;
   logic idex_wen = 0, idex_load = 0, exm_wen = 0, mwb_wen = 0, br_taken = 0;
   logic [2*NO-1:0] fwd_sel;
   logic pc_hold, ifid_hold, bubble_ins, ifid_flush;

   always #4 clk = ~clk;

   bypass_interlock_unit #(.REG_AW(AW), .NUM_OPS(NO)) dut_i (
      .clk(clk), .rst_n(rst_n), .ex_src(ex_src), .id_src(id_src),
      .idex_dst(idex_dst), .idex_wen(idex_wen), .idex_load(idex_load),
      .exm_dst(exm_dst), .exm_wen(exm_wen), .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
      .br_taken(br_taken), .fwd_sel(fwd_sel), .pc_hold(pc_hold),
      .ifid_hold(ifid_hold), .bubble_ins(bubble_ins), .ifid_flush(ifid_flush));

   typedef struct {
      logic [7:0] outs;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;

   function automatic logic [1:0] pick(input logic [AW-1:0] s, input logic [AW-1:0] ed,
                                       input logic ew, input logic [AW-1:0] md, input logic mw);
      if (ew && ed != 0 && ed == s) return 2'b10;
      if (mw && md != 0 && md == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic apply(input logic [AW-1:0] ea, input logic [AW-1:0] eb,
                        input logic [AW-1:0] ia, input logic [AW-1:0] ib,
                        input logic [AW-1:0] idd, input logic idw, input logic idl,
                        input logic [AW-1:0] ed, input logic ew,
                        input logic [AW-1:0] md, input logic mw,
                        input logic br, input string tag);
      exp_t e;
      logic st;
      @(negedge clk);
      ex_src = {eb, ea}; id_src = {ib, ia};
      idex_dst = idd; idex_wen = idw; idex_load = idl;
      exm_dst = ed; exm_wen = ew; mwb_dst = md; mwb_wen = mw; br_taken = br;
      st = idl && idw && idd != 0 && (idd == ia || idd == ib);
      e.outs = {pick(eb, ed, ew, md, mw), pick(ea, ed, ew, md, mw),
                st, st, st, br && !st};
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compare after each rising edge, away from it
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() != 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb_q.pop_front();
            act = {fwd_sel, pc_hold, ifid_hold, bubble_ins, ifid_flush};
            n_checks++;
            if (act !== e.outs) begin
               n_errors++;
               $display("FAIL %s: actual=%b expected=%b", e.tag, act, e.outs);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // reset state: all quiet
      apply(0,0,0,0, 0,0,0, 0,0, 0,0, 0, "R1 reset idle");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      apply(3,4,1,2, 9,1,0, 6,1, 7,1, 0, "R1 no match");
      apply(3,4,1,2, 9,1,0, 3,1, 7,0, 0, "R2 exm to A");
      apply(3,7,1,2, 9,1,0, 6,1, 7,1, 0, "R3 mwb to B");
      apply(5,2,1,2, 9,1,0, 5,1, 5,1, 0, "R4 both match A");
      apply(0,0,1,2, 9,1,0, 0,1, 0,1, 0, "R5 reg zero");
      apply(8,8,1,2, 9,1,0, 8,0, 8,1, 0, "R6 exm wen off");
      apply(8,8,1,2, 9,1,0, 8,0, 8,0, 0, "R6 both wen off");
      apply(10,11,1,2, 9,1,0, 10,1, 11,1, 0, "R2 R3 split operands");
      apply(1,2,4,6, 4,1,1, 0,0, 0,0, 0, "R7 load hit A");
      apply(1,2,6,4, 4,1,1, 0,0, 0,0, 0, "R7 load hit B");
      apply(1,2,4,4, 4,1,0, 0,0, 0,0, 0, "R8 alu no stall");
      apply(1,2,0,6, 0,1,1, 0,0, 0,0, 0, "R7 load to zero");
      apply(1,2,3,6, 4,1,1, 0,0, 0,0, 0, "R7 load no hit");
      apply(1,2,3,6, 4,1,1, 0,0, 0,0, 1, "R9 branch flush");
      apply(1,2,3,4, 4,1,1, 0,0, 0,0, 1, "R10 branch during stall");
      apply(3,3,1,2, 9,1,0, 3,1, 3,1, 1, "R4 R9 mixed");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule